// File: doc/BRIEF.md
# Reduced-Power Mode and Bus-Pin Controller

This block governs the two low-power states of a small 8-bit microcontroller core. It divides the incoming clock by two to form the internal phase. It gives the CPU, the general peripherals, the DMA engine and the oscillator a synchronous enable each. The clock nets themselves are never gated. Software asks for idle or power-down. A pending enabled interrupt brings the core out of idle. Only the asynchronous hardware reset brings it out of power-down.

While the core is in either low-power state, the block also drives override values for the external bus pins. It sets the level of the address-latch and program-fetch strobes. It controls whether the multiplexed low address/data port floats. It chooses whether the high port shows the upper address byte or its latched data. These choices depend on the mode and on whether code is fetched from external program memory.

Top module: `lpc_ctrl`

## Requirements
- R1: While the oscillator runs, `clk_phase` toggles on every `clk_in` rising edge, starting at 0 after reset. `cpu_en`, `dma_en` and `periph_en` are only ever high in cycles where `clk_phase` is 1.
- R2: Requests are sampled only on rising edges where `clk_phase` is 1. A sampled `req_idle` while running enters idle. In idle, `cpu_en` and `dma_en` stay low and `periph_en` keeps following `clk_phase`.
- R3: In idle, `irq_pend` sampled on a `clk_phase`=1 edge returns the core to running. `cpu_en` then rises at the next `clk_phase`=1 cycle. Requests sampled during idle are ignored.
- R4: In power-down, `osc_en` and all three enables are low and `clk_phase` holds its value. `irq_pend`, `req_idle` and `req_pdown` have no effect, and only reset leaves the mode.
- R5: If `req_idle` and `req_pdown` are both sampled while running, power-down is entered.
- R6: `pin_ovr` is 1 in both low-power modes and 0 while running. `ale_lvl` and `psen_lvl` are 1 in idle and 0 in power-down and while running.
- R7: With `ext_code`=1, `lo_float` is 1 in both low-power modes. `hi_addr_sel` is 1 (upper address byte) in idle and 0 (latched data) in power-down.
- R8: With `ext_code`=0, `lo_float` and `hi_addr_sel` stay 0 in every mode, so every port keeps its latched data.
- R9: Asserting `rst_n` low takes effect at once, without waiting for a clock edge. It sets the mode to running, releases all pin overrides (`pin_ovr`, `lo_float`, `hi_addr_sel`, `ale_lvl`, `psen_lvl` all 0) and clears `clk_phase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock (any duty cycle) |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| req_idle | input | 1 | Software request to enter idle |
| req_pdown | input | 1 | Software request to enter power-down |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_code | input | 1 | 1 = code fetched from external program memory |
| clk_phase | output | 1 | Divide-by-two internal phase |
| cpu_en | output | 1 | CPU clock enable |
| periph_en | output | 1 | General peripheral clock enable |
| dma_en | output | 1 | DMA channel clock enable |
| osc_en | output | 1 | Oscillator run enable |
| pin_ovr | output | 1 | Bus-pin override active |
| ale_lvl | output | 1 | Forced address-latch strobe level |
| psen_lvl | output | 1 | Forced program-fetch strobe level |
| lo_float | output | 1 | Float the multiplexed low address/data port |
| hi_addr_sel | output | 1 | High port shows address byte (1) or latched data (0) |

## Verification
The assertions assume that reset is low at time zero. They also assume that every input is steady across each rising edge of `clk_in`, so each sampled request has a single value. The bench changes inputs only at falling edges and pulses reset from there. It keeps `req_pdown` rare and resets often, so the run does not sit in power-down. A model in the bench steps the phase and the mode at every rising edge and predicts every output.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pmode_e;

    typedef struct packed {
        logic phase;
    } phase_st_t;

    typedef struct packed {
        pmode_e mode;
    } mode_st_t;
endpackage

// File: rtl/lpc_phase.sv
module lpc_phase #(
    parameter logic PHASE_INIT = 1'b0
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic osc_en,
    output logic phase
);
    import lpc_pkg::*;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (osc_en) begin
            st_d.phase = ~st_q.phase;
        end
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PHASE_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;

    // R1: running oscillator flips the phase on every input edge
    assert_phase_toggle_R1: assert property (@(posedge clk_in) disable iff (!rst_n)
        osc_en |=> (phase != $past(phase)));

    // R4: stopped oscillator freezes the phase
    assert_phase_frozen_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
        !osc_en |=> $stable(phase));
endmodule

// File: rtl/lpc_mode.sv
module lpc_mode (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           req_idle,
    input  logic           req_pdown,
    input  logic           irq_pend,
    output lpc_pkg::pmode_e mode
);
    import lpc_pkg::*;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            unique case (st_q.mode)
                PM_RUN: begin
                    if (req_pdown) begin
                        st_d.mode = PM_DOWN;
                    end else if (req_idle) begin
                        st_d.mode = PM_IDLE;
                    end
                end
                PM_IDLE: begin
                    if (irq_pend) begin
                        st_d.mode = PM_RUN;
                    end
                end
                PM_DOWN: st_d.mode = PM_DOWN;
                default: st_d.mode = PM_RUN;
            endcase
        end
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= PM_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;

    // R4: only reset leaves power-down
    assert_pdown_sticky_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
        (mode == PM_DOWN) |=> (mode == PM_DOWN));

    // R3: a sampled interrupt ends idle
    assert_idle_exit_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        (mode == PM_IDLE && tick && irq_pend) |=> (mode == PM_RUN));

    // R5: power-down wins over idle
    assert_pdown_prio_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
        (mode == PM_RUN && tick && req_pdown) |=> (mode == PM_DOWN));

    // R2: requests off the active phase are not taken
    assert_no_offphase_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
        !tick |=> $stable(mode));
endmodule

// File: rtl/lpc_pins.sv
module lpc_pins (
    input  lpc_pkg::pmode_e mode,
    input  logic            ext_code,
    input  logic            tick,
    output logic            cpu_en,
    output logic            periph_en,
    output logic            dma_en,
    output logic            osc_en,
    output logic            pin_ovr,
    output logic            ale_lvl,
    output logic            psen_lvl,
    output logic            lo_float,
    output logic            hi_addr_sel
);
    import lpc_pkg::*;

    logic is_run, is_idle, is_down;

    always_comb begin
        is_run  = (mode == PM_RUN);
        is_idle = (mode == PM_IDLE);
        is_down = (mode == PM_DOWN);

        cpu_en      = tick & is_run;
        dma_en      = tick & is_run;
        periph_en   = tick & (is_run | is_idle);
        osc_en      = ~is_down;

        pin_ovr     = is_idle | is_down;
        ale_lvl     = is_idle;
        psen_lvl    = is_idle;
        lo_float    = ext_code & (is_idle | is_down);
        hi_addr_sel = ext_code & is_idle;
    end
endmodule

// File: rtl/lpc_ctrl.sv
module lpc_ctrl (
    input  logic clk_in,
    input  logic rst_n,
    input  logic req_idle,
    input  logic req_pdown,
    input  logic irq_pend,
    input  logic ext_code,
    output logic clk_phase,
    output logic cpu_en,
    output logic periph_en,
    output logic dma_en,
    output logic osc_en,
    output logic pin_ovr,
    output logic ale_lvl,
    output logic psen_lvl,
    output logic lo_float,
    output logic hi_addr_sel
);
    import lpc_pkg::*;

    pmode_e mode;

    lpc_phase #(.PHASE_INIT(1'b0)) u_phase (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .osc_en (osc_en),
        .phase  (clk_phase)
    );

    lpc_mode u_mode (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .tick      (clk_phase),
        .req_idle  (req_idle),
        .req_pdown (req_pdown),
        .irq_pend  (irq_pend),
        .mode      (mode)
    );

    lpc_pins u_pins (
        .mode        (mode),
        .ext_code    (ext_code),
        .tick        (clk_phase),
        .cpu_en      (cpu_en),
        .periph_en   (periph_en),
        .dma_en      (dma_en),
        .osc_en      (osc_en),
        .pin_ovr     (pin_ovr),
        .ale_lvl     (ale_lvl),
        .psen_lvl    (psen_lvl),
        .lo_float    (lo_float),
        .hi_addr_sel (hi_addr_sel)
    );

    // R1: no enable outside the active phase
    assert_en_in_phase_R1: assert property (@(posedge clk_in) disable iff (!rst_n)
        (cpu_en | dma_en | periph_en) |-> clk_phase);

    // R6: a running CPU never sees pin overrides
    assert_run_no_ovr_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
        cpu_en |-> (!pin_ovr && osc_en && !lo_float));

    // R4: stopped oscillator leaves nothing clocked
    assert_down_quiet_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
        !osc_en |-> !(cpu_en | dma_en | periph_en));
endmodule

// File: tb/lpc_ctrl_test.sv
module lpc_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int M_RUN = 0;
    localparam int M_IDLE = 1;
    localparam int M_DOWN = 2;

    logic clk_in = 1'b0;
    logic rst_n = 1'b0;
    logic req_idle = 1'b0, req_pdown = 1'b0, irq_pend = 1'b0, ext_code = 1'b0;
    logic clk_phase, cpu_en, periph_en, dma_en, osc_en;
    logic pin_ovr, ale_lvl, psen_lvl, lo_float, hi_addr_sel;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;
    int m_mode = M_RUN;
    bit m_phase = 1'b0;

    always #(CLK_PERIOD/2) clk_in = ~clk_in;

    lpc_ctrl uut (
        .clk_in(clk_in), .rst_n(rst_n), .req_idle(req_idle), .req_pdown(req_pdown),
        .irq_pend(irq_pend), .ext_code(ext_code), .clk_phase(clk_phase),
        .cpu_en(cpu_en), .periph_en(periph_en), .dma_en(dma_en), .osc_en(osc_en),
        .pin_ovr(pin_ovr), .ale_lvl(ale_lvl), .psen_lvl(psen_lvl),
        .lo_float(lo_float), .hi_addr_sel(hi_addr_sel)
    );

    function automatic bit exp_cpu();   return m_phase && m_mode == M_RUN; endfunction
    function automatic bit exp_per();   return m_phase && m_mode != M_DOWN; endfunction
    function automatic bit exp_osc();   return m_mode != M_DOWN; endfunction
    function automatic bit exp_ovr();   return m_mode != M_RUN; endfunction
    function automatic bit exp_strb();  return m_mode == M_IDLE; endfunction
    function automatic bit exp_float(); return ext_code && m_mode != M_RUN; endfunction
    function automatic bit exp_hi();    return ext_code && m_mode == M_IDLE; endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R1 clk_phase", clk_phase, m_phase);
        chk("R2 cpu_en", cpu_en, exp_cpu());
        chk("R2 dma_en", dma_en, exp_cpu());
        chk("R2 periph_en", periph_en, exp_per());
        chk("R4 osc_en", osc_en, exp_osc());
        chk("R6 pin_ovr", pin_ovr, exp_ovr());
        chk("R6 ale_lvl", ale_lvl, exp_strb());
        chk("R6 psen_lvl", psen_lvl, exp_strb());
        chk("R7 lo_float", lo_float, exp_float());
        chk("R7 hi_addr_sel", hi_addr_sel, exp_hi());
    endtask

    // one clk_in cycle: drive at the falling edge, check, then advance the model
    task automatic step(input logic rn, input logic ri, input logic rp,
                        input logic ir, input logic ec);
        @(negedge clk_in);
        rst_n = rn; req_idle = ri; req_pdown = rp; irq_pend = ir; ext_code = ec;
        if (!rn) begin
            m_mode = M_RUN;
            m_phase = 1'b0;
        end
        #1;
        check_all();
        @(posedge clk_in);
        if (rn && m_mode != M_DOWN) begin
            if (m_phase) begin
                if (m_mode == M_RUN) begin
                    if (rp) m_mode = M_DOWN;
                    else if (ri) m_mode = M_IDLE;
                end else if (ir) begin
                    m_mode = M_RUN;
                end
            end
            m_phase = ~m_phase;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic ec;
        void'($urandom(32'h5EED_0152));
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        for (int e = 0; e < 2; e++) begin
            ec = logic'(e);
            // R9: reset state
            step(0, 0, 0, 0, ec);
            for (int k = 0; k < 3; k++) step(1, 0, 0, 0, ec);
            // R2/R6/R7/R8: idle entry, requests ignored in idle
            step(1, 1, 0, 0, ec); step(1, 1, 0, 0, ec);
            for (int k = 0; k < 4; k++) step(1, 1, 0, 0, ec);
            // R3: interrupt ends idle
            step(1, 0, 0, 1, ec); step(1, 0, 0, 1, ec);
            for (int k = 0; k < 3; k++) step(1, 0, 0, 0, ec);
            // R5: both requests, power-down wins
            step(1, 1, 1, 0, ec); step(1, 1, 1, 0, ec);
            // R4: interrupts and requests ignored in power-down
            for (int k = 0; k < 6; k++) step(1, 1, 0, 1, ec);
            // R9: reset from power-down takes effect at once
            step(0, 0, 0, 1, ec);
            step(1, 0, 0, 0, ec);
        end
        for (int i = 0; i < 20000; i++) begin
            step(($urandom % 25) != 0,
                 ($urandom % 6) == 0,
                 ($urandom % 30) == 0,
                 ($urandom % 4) == 0,
                 (($urandom % 8) == 0) ? ~ext_code : ext_code);
        end
        finish_run();
    end
endmodule